// File: doc/BRIEF.md
# Interrupt Controller Command Register Interface

This block is the byte-wide, two-address programming port of an eight-line interrupt controller. Software writes a start-of-initialization word at the low address. The block then walks through a short setup sequence at the high address. That sequence sets the vector base, optionally takes a cascade word, and optionally takes a mode word. Afterwards, high-address writes load the interrupt mask, and low-address writes carry run-time commands. Those commands cover end-of-interrupt variants, priority rotation, read-back selection, special mask mode and polling.

The block does not hold the request or in-service registers itself. It receives them from the controller core and returns in-service clear strobes and a one-cycle clear pulse for the core's request and in-service state. It also receives the priority resolver's current winner and returns it on a poll read. It drives the mask, the vector base, the mode flags and the rotating priority offset. The line numbered by the offset has the highest priority, and priority falls as the line number rises modulo 8.

Top module: `pic_cmd_if`

## Requirements
- R1: After reset the mask, vector base, priority offset and every mode flag read 0, the setup sequencer is idle, and a low-address read returns the request input.
- R2: A low-address write with bit 4 set starts setup. It captures single mode from bit 1 and mode-word-needed from bit 0. It clears the mask, the priority offset, the special-fully-nested, auto-EOI, rotate and special-mask flags, the read select (back to requests) and any pending poll. It pulses `init_clr_o` for exactly one cycle.
- R3: The first high-address write after R2 stores the vector base as data with bits 2:0 forced to 0. The next step is the cascade word when not in single mode. In single mode the next step is the mode word if one is needed, and otherwise the sequence ends. After the cascade word the next step is the mode word if one is needed, and otherwise the sequence ends.
- R4: The mode word sets special-fully-nested from bit 4 and auto-EOI from bit 1, then ends the sequence.
- R5: Outside setup, a high-address write loads the mask, and a high-address read returns it. The mask does not change on any cycle without such a write or an R2 write.
- R6: A low-address write with bit 4 clear and bit 3 set is a read/mask command. When its bit 1 is set, bit 0 picks what a low-address read returns (1 = in-service, 0 = request). When bit 1 is clear, the read select is left unchanged. Bits 6:5 = 11 set special mask mode, 10 clears it, and other values leave it unchanged.
- R7: A read/mask command with bit 2 set arms a poll. The next read at either address returns {1, 0000, winner line} when the resolver reports a request, or 0x00 when it does not. That read disarms the poll, and later reads behave normally.
- R8: A low-address write with bits 4 and 3 clear is a command with code = bits 7:5. Code 4 sets the rotate-on-auto-EOI flag and code 0 clears it.
- R9: Code 1 (non-specific EOI) pulses the `isr_clr_o` bit of the highest-priority in-service line, searching from the offset line upward modulo 8. With no line in service it pulses nothing and changes nothing.
- R10: Code 5 acts as code 1 and also sets the offset to (cleared line + 1) mod 8. With no line in service it changes nothing.
- R11: Code 3 pulses the clear of line data[2:0]. Code 7 does the same and sets the offset to (data[2:0] + 1) mod 8. Code 6 only sets the offset to (data[2:0] + 1) mod 8. Code 2 has no effect.
- R12: `isr_clr_o` is one-hot or zero, appears in the cycle after the command write, and lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| addr_i | input | 1 | Register address bit |
| wdata_i | input | 8 | Write data |
| irr_i | input | 8 | Request register from the core |
| isr_i | input | 8 | In-service register from the core |
| req_valid_i | input | 1 | Resolver reports a pending winner |
| req_line_i | input | 3 | Resolver winning line |
| rdata_o | output | 8 | Read data |
| imr_o | output | 8 | Interrupt mask |
| vec_base_o | output | 8 | Vector base, bits 2:0 zero |
| single_o | output | 1 | Single (non-cascaded) mode |
| sfnm_o | output | 1 | Special fully nested mode |
| aeoi_o | output | 1 | Auto end-of-interrupt mode |
| rot_aeoi_o | output | 1 | Rotate on auto end-of-interrupt |
| smm_o | output | 1 | Special mask mode |
| prio_add_o | output | 3 | Highest-priority line (rotation offset) |
| isr_clr_o | output | 8 | One-cycle in-service clear strobes |
| init_clr_o | output | 1 | One-cycle clear pulse for request and in-service state |

## Verification
The hardest case to reach from the ports is a non-specific end-of-interrupt after the priority offset has been rotated. In that case the search must wrap past line 7 to find the in-service line. The stimulus first moves the offset with the set-priority and rotating EOI commands. It then holds an in-service pattern whose set lines lie both above and below the offset. The expected strobe is computed by walking the lines from the offset in the bench. An empty in-service input is also driven with both EOI forms to confirm that neither the strobes nor the offset move.

// File: rtl/pic_cmd_pkg.sv
package pic_cmd_pkg;
  localparam int unsigned DW    = 8;
  localparam int unsigned LINES = 8;
  localparam int unsigned LW    = $clog2(LINES);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BASE = 2'd1,
    ST_CASC = 2'd2,
    ST_MODE = 2'd3
  } init_st_e;

  typedef enum logic [2:0] {
    OP_ROT_CLR    = 3'd0,
    OP_EOI_NS     = 3'd1,
    OP_NOP        = 3'd2,
    OP_EOI_SP     = 3'd3,
    OP_ROT_SET    = 3'd4,
    OP_EOI_NS_ROT = 3'd5,
    OP_SET_PRIO   = 3'd6,
    OP_EOI_SP_ROT = 3'd7
  } ocw2_op_e;

  typedef struct packed {
    logic          hit;
    logic [LW-1:0] line;
  } pick_t;

  // first set bit of mask, searching upward from base with wrap
  function automatic pick_t pick_top(input logic [LINES-1:0] mask,
                                     input logic [LW-1:0] base);
    pick_t         res;
    logic [LW-1:0] idx;
    res = '0;
    for (int k = LINES - 1; k >= 0; k--) begin
      idx = base + LW'(k);
      if (mask[idx]) begin
        res.hit  = 1'b1;
        res.line = idx;
      end
    end
    return res;
  endfunction
endpackage

// File: rtl/pic_cmd_decode.sv
module pic_cmd_decode (
  input  logic       wr_i,
  input  logic       addr_i,
  input  logic [1:0] sel_i,   // wdata[4:3]
  output logic       icw1_we_o,
  output logic       ocw2_we_o,
  output logic       ocw3_we_o,
  output logic       data_we_o
);
  logic lo_we;
  assign lo_we     = wr_i & ~addr_i;
  assign icw1_we_o = lo_we & sel_i[1];
  assign ocw3_we_o = lo_we & ~sel_i[1] & sel_i[0];
  assign ocw2_we_o = lo_we & ~sel_i[1] & ~sel_i[0];
  assign data_we_o = wr_i & addr_i;
endmodule

// File: rtl/pic_init_seq.sv
module pic_init_seq
  import pic_cmd_pkg::*;
#(
  parameter int unsigned W        = DW,
  parameter int unsigned BASE_LSB = LW
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         icw1_we_i,
  input  logic         data_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] imr_o,
  output logic [W-1:0] vec_base_o,
  output logic         single_o,
  output logic         sfnm_o,
  output logic         aeoi_o
);
  init_st_e     state_q;
  logic         need4_q, single_q, sfnm_q, aeoi_q;
  logic [W-1:0] imr_q, base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      need4_q  <= 1'b0;
      single_q <= 1'b0;
      sfnm_q   <= 1'b0;
      aeoi_q   <= 1'b0;
      imr_q    <= '0;
      base_q   <= '0;
    end else if (icw1_we_i) begin
      state_q  <= ST_BASE;
      single_q <= wdata_i[1];
      need4_q  <= wdata_i[0];
      sfnm_q   <= 1'b0;
      aeoi_q   <= 1'b0;
      imr_q    <= '0;
    end else if (data_we_i) begin
      unique case (state_q)
        ST_IDLE: imr_q <= wdata_i;
        ST_BASE: begin
          base_q  <= {wdata_i[W-1:BASE_LSB], {BASE_LSB{1'b0}}};
          state_q <= single_q ? (need4_q ? ST_MODE : ST_IDLE) : ST_CASC;
        end
        ST_CASC: state_q <= need4_q ? ST_MODE : ST_IDLE;
        ST_MODE: begin
          sfnm_q  <= wdata_i[4];
          aeoi_q  <= wdata_i[1];
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign imr_o      = imr_q;
  assign vec_base_o = base_q;
  assign single_o   = single_q;
  assign sfnm_o     = sfnm_q;
  assign aeoi_o     = aeoi_q;

  a_r5_imr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!data_we_i && !icw1_we_i) |=> $stable(imr_q));
  a_r2_icw1_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    icw1_we_i |=> (imr_q == '0 && state_q == ST_BASE));
  a_r3_casc_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CASC && data_we_i && !icw1_we_i) |=>
      (state_q == ST_MODE || state_q == ST_IDLE));
endmodule

// File: rtl/pic_ocw_exec.sv
module pic_ocw_exec
  import pic_cmd_pkg::*;
#(
  parameter int unsigned N  = LINES,
  parameter int unsigned NW = LW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          icw1_we_i,
  input  logic          ocw2_we_i,
  input  logic          ocw3_we_i,
  input  logic          rd_i,
  input  logic [2:0]    op_i,     // wdata[7:5]
  input  logic [2:0]    lo_i,     // wdata[2:0]
  input  logic [N-1:0]  isr_i,
  output logic [NW-1:0] prio_add_o,
  output logic          rot_aeoi_o,
  output logic          smm_o,
  output logic          rd_isr_o,
  output logic          poll_o,
  output logic [N-1:0]  isr_clr_o
);
  logic [NW-1:0] prio_q, prio_d, lo_line;
  logic          rot_q, rot_d, smm_q, rd_isr_q, poll_q;
  logic [N-1:0]  clr_q, clr_d;
  pick_t         top;
  ocw2_op_e      op;

  assign op      = ocw2_op_e'(op_i);
  assign lo_line = NW'(lo_i);
  assign top     = pick_top(isr_i, prio_q);

  always_comb begin
    clr_d  = '0;
    prio_d = prio_q;
    rot_d  = rot_q;
    if (ocw2_we_i) begin
      unique case (op)
        OP_ROT_CLR: rot_d = 1'b0;
        OP_ROT_SET: rot_d = 1'b1;
        OP_EOI_NS: if (top.hit) clr_d[top.line] = 1'b1;
        OP_EOI_NS_ROT: if (top.hit) begin
          clr_d[top.line] = 1'b1;
          prio_d          = NW'(top.line + 1'b1);
        end
        OP_EOI_SP: clr_d[lo_line] = 1'b1;
        OP_EOI_SP_ROT: begin
          clr_d[lo_line] = 1'b1;
          prio_d         = NW'(lo_line + 1'b1);
        end
        OP_SET_PRIO: prio_d = NW'(lo_line + 1'b1);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prio_q   <= '0;
      rot_q    <= 1'b0;
      smm_q    <= 1'b0;
      rd_isr_q <= 1'b0;
      poll_q   <= 1'b0;
      clr_q    <= '0;
    end else if (icw1_we_i) begin
      prio_q   <= '0;
      rot_q    <= 1'b0;
      smm_q    <= 1'b0;
      rd_isr_q <= 1'b0;
      poll_q   <= 1'b0;
      clr_q    <= '0;
    end else begin
      clr_q  <= clr_d;
      prio_q <= prio_d;
      rot_q  <= rot_d;
      if (ocw3_we_i && op_i[1]) smm_q <= op_i[0];  // bits 6:5
      if (ocw3_we_i && lo_i[1]) rd_isr_q <= lo_i[0];
      if (ocw3_we_i && lo_i[2]) poll_q <= 1'b1;
      else if (rd_i)            poll_q <= 1'b0;
    end
  end

  assign prio_add_o = prio_q;
  assign rot_aeoi_o = rot_q;
  assign smm_o      = smm_q;
  assign rd_isr_o   = rd_isr_q;
  assign poll_o     = poll_q;
  assign isr_clr_o  = clr_q;

  a_r12_clr_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(clr_q));
  a_r12_clr_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_q != '0 && !ocw2_we_i) |=> (clr_q == '0));
  a_r9_empty_eoi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ocw2_we_i && !icw1_we_i && (op == OP_EOI_NS || op == OP_EOI_NS_ROT) && isr_i == '0)
      |=> (clr_q == '0 && $stable(prio_q)));
  a_r7_poll_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && poll_q && !ocw3_we_i) |=> !poll_q);
endmodule

// File: rtl/pic_readback.sv
module pic_readback
  import pic_cmd_pkg::*;
#(
  parameter int unsigned W  = DW,
  parameter int unsigned NW = LW
) (
  input  logic          addr_i,
  input  logic          poll_i,
  input  logic          rd_isr_i,
  input  logic [W-1:0]  irr_i,
  input  logic [W-1:0]  isr_i,
  input  logic [W-1:0]  imr_i,
  input  logic          req_valid_i,
  input  logic [NW-1:0] req_line_i,
  output logic [W-1:0]  rdata_o
);
  localparam int unsigned PAD = W - 1 - NW;
  always_comb begin
    if (poll_i)
      rdata_o = req_valid_i ? {1'b1, {PAD{1'b0}}, req_line_i} : '0;
    else if (addr_i)
      rdata_o = imr_i;
    else
      rdata_o = rd_isr_i ? isr_i : irr_i;
  end
endmodule

// File: rtl/pic_cmd_if.sv
module pic_cmd_if
  import pic_cmd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic             addr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [LINES-1:0] irr_i,
  input  logic [LINES-1:0] isr_i,
  input  logic             req_valid_i,
  input  logic [LW-1:0]    req_line_i,
  output logic [DW-1:0]    rdata_o,
  output logic [LINES-1:0] imr_o,
  output logic [DW-1:0]    vec_base_o,
  output logic             single_o,
  output logic             sfnm_o,
  output logic             aeoi_o,
  output logic             rot_aeoi_o,
  output logic             smm_o,
  output logic [LW-1:0]    prio_add_o,
  output logic [LINES-1:0] isr_clr_o,
  output logic             init_clr_o
);
  logic icw1_we, ocw2_we, ocw3_we, data_we;
  logic rd_isr, poll;
  logic init_clr_q;

  pic_cmd_decode i_decode (
    .wr_i      (wr_i),
    .addr_i    (addr_i),
    .sel_i     (wdata_i[4:3]),
    .icw1_we_o (icw1_we),
    .ocw2_we_o (ocw2_we),
    .ocw3_we_o (ocw3_we),
    .data_we_o (data_we)
  );

  pic_init_seq i_init (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .icw1_we_i  (icw1_we),
    .data_we_i  (data_we),
    .wdata_i    (wdata_i),
    .imr_o      (imr_o),
    .vec_base_o (vec_base_o),
    .single_o   (single_o),
    .sfnm_o     (sfnm_o),
    .aeoi_o     (aeoi_o)
  );

  pic_ocw_exec i_exec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .icw1_we_i  (icw1_we),
    .ocw2_we_i  (ocw2_we),
    .ocw3_we_i  (ocw3_we),
    .rd_i       (rd_i),
    .op_i       (wdata_i[7:5]),
    .lo_i       (wdata_i[2:0]),
    .isr_i      (isr_i),
    .prio_add_o (prio_add_o),
    .rot_aeoi_o (rot_aeoi_o),
    .smm_o      (smm_o),
    .rd_isr_o   (rd_isr),
    .poll_o     (poll),
    .isr_clr_o  (isr_clr_o)
  );

  pic_readback i_rdback (
    .addr_i      (addr_i),
    .poll_i      (poll),
    .rd_isr_i    (rd_isr),
    .irr_i       (irr_i),
    .isr_i       (isr_i),
    .imr_i       (imr_o),
    .req_valid_i (req_valid_i),
    .req_line_i  (req_line_i),
    .rdata_o     (rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) init_clr_q <= 1'b0;
    else         init_clr_q <= icw1_we;
  end
  assign init_clr_o = init_clr_q;

  a_r2_init_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_clr_q && !icw1_we) |=> !init_clr_q);
endmodule

// File: tb/test_pic_cmd_if.sv
module test_pic_cmd_if;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_i = 1'b0, rd_i = 1'b0, addr_i = 1'b0;
  logic [7:0] wdata_i = '0, irr_i = '0, isr_i = '0;
  logic       req_valid_i = 1'b0;
  logic [2:0] req_line_i = '0;
  logic [7:0] rdata_o, imr_o, vec_base_o, isr_clr_o;
  logic       single_o, sfnm_o, aeoi_o, rot_aeoi_o, smm_o, init_clr_o;
  logic [2:0] prio_add_o;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } sb_item_t;
  sb_item_t sb_q[$];
  event     rd_ev;

  always #10 clk_i = ~clk_i;  // 50 MHz

  pic_cmd_if i_pic_cmd_if (.*);

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk_i);
    wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic rd(input logic a, input logic [7:0] exp, input string tag);
    sb_item_t it;
    @(negedge clk_i);
    addr_i = a; rd_i = 1'b1;
    it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    ->rd_ev;
    @(negedge clk_i);
    rd_i = 1'b0;
  endtask

  // monitor: compares read data against queued expectations
  initial begin
    sb_item_t it;
    forever begin
      @(rd_ev);
      #5;
      it = sb_q.pop_front();
      chk(it.tag, rdata_o, it.exp);
    end
  end

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    irr_i = 8'h5A; isr_i = 8'h28;
    @(negedge clk_i);
    // R1 reset state
    chk("R1 imr", imr_o, 8'h00);
    chk("R1 base", vec_base_o, 8'h00);
    chk("R1 prio", {5'b0, prio_add_o}, 8'h00);
    chk("R1 flags", {2'b0, single_o, sfnm_o, aeoi_o, rot_aeoi_o, smm_o, init_clr_o}, 8'h00);
    rd(1'b0, 8'h5A, "R1 read irr");
    wr(1'b1, 8'h33);
    chk("R1 idle mask write", imr_o, 8'h33);

    // R2/R3/R4 cascade + mode word
    wr(1'b0, 8'h11);
    chk("R2 init pulse", {7'b0, init_clr_o}, 8'h01);
    chk("R2 imr cleared", imr_o, 8'h00);
    @(negedge clk_i);
    chk("R2 pulse one cycle", {7'b0, init_clr_o}, 8'h00);
    wr(1'b1, 8'h47);
    chk("R3 base masked", vec_base_o, 8'h40);
    wr(1'b1, 8'h04);
    chk("R3 cascade word leaves imr", imr_o, 8'h00);
    wr(1'b1, 8'h12);
    chk("R4 sfnm", {7'b0, sfnm_o}, 8'h01);
    chk("R4 aeoi", {7'b0, aeoi_o}, 8'h01);
    wr(1'b1, 8'hA5);
    chk("R5 imr", imr_o, 8'hA5);
    rd(1'b1, 8'hA5, "R5 read imr");

    // R2/R3 single, no mode word
    wr(1'b0, 8'h12);
    chk("R2 clears sfnm/aeoi", {6'b0, sfnm_o, aeoi_o}, 8'h00);
    chk("R2 single", {7'b0, single_o}, 8'h01);
    wr(1'b1, 8'hFF);
    chk("R3 base single", vec_base_o, 8'hF8);
    wr(1'b1, 8'h3C);
    chk("R3 single ends at base", imr_o, 8'h3C);

    // R3/R4 single with mode word
    wr(1'b0, 8'h13);
    wr(1'b1, 8'h08);
    chk("R3 base 08", vec_base_o, 8'h08);
    wr(1'b1, 8'h02);
    chk("R4 aeoi only", {6'b0, sfnm_o, aeoi_o}, 8'h01);
    chk("R4 imr untouched", imr_o, 8'h00);
    wr(1'b1, 8'h81);
    chk("R5 imr after mode", imr_o, 8'h81);

    // R6 read select and special mask
    wr(1'b0, 8'h0B);
    rd(1'b0, 8'h28, "R6 select isr");
    wr(1'b0, 8'h08);
    rd(1'b0, 8'h28, "R6 select unchanged");
    wr(1'b0, 8'h0A);
    rd(1'b0, 8'h5A, "R6 select irr");
    wr(1'b0, 8'h68);
    chk("R6 smm set", {7'b0, smm_o}, 8'h01);
    wr(1'b0, 8'h28);
    chk("R6 smm unchanged", {7'b0, smm_o}, 8'h01);
    wr(1'b0, 8'h48);
    chk("R6 smm clear", {7'b0, smm_o}, 8'h00);

    // R7 poll
    req_valid_i = 1'b1; req_line_i = 3'd5;
    wr(1'b0, 8'h0C);
    rd(1'b1, 8'h85, "R7 poll result");
    rd(1'b1, 8'h81, "R7 poll disarmed");
    req_valid_i = 1'b0;
    wr(1'b0, 8'h0C);
    rd(1'b0, 8'h00, "R7 poll empty");
    rd(1'b0, 8'h5A, "R7 normal after empty poll");

    // R8 rotate flag
    wr(1'b0, 8'h80);
    chk("R8 rotate set", {7'b0, rot_aeoi_o}, 8'h01);
    wr(1'b0, 8'h00);
    chk("R8 rotate clear", {7'b0, rot_aeoi_o}, 8'h00);

    // R9 non-specific EOI, offset 0, isr lines 3 and 5
    isr_i = 8'h28;
    wr(1'b0, 8'h20);
    chk("R9 clear top line", isr_clr_o, 8'h08);
    @(negedge clk_i);
    chk("R12 strobe one cycle", isr_clr_o, 8'h00);
    isr_i = 8'h00;
    wr(1'b0, 8'h20);
    chk("R9 empty no strobe", isr_clr_o, 8'h00);
    chk("R9 empty offset", {5'b0, prio_add_o}, 8'h00);

    // R11 set priority, then R9 with offset 5
    wr(1'b0, 8'hC4);
    chk("R11 set prio", {5'b0, prio_add_o}, 8'h05);
    isr_i = 8'h28;
    wr(1'b0, 8'h20);
    chk("R9 rotated search", isr_clr_o, 8'h20);

    // R10 rotating non-specific EOI
    wr(1'b0, 8'hA0);
    chk("R10 clear", isr_clr_o, 8'h20);
    chk("R10 offset", {5'b0, prio_add_o}, 8'h06);
    wr(1'b0, 8'h20);
    chk("R9 wrap search", isr_clr_o, 8'h08);
    isr_i = 8'h00;
    wr(1'b0, 8'hA0);
    chk("R10 empty no strobe", isr_clr_o, 8'h00);
    chk("R10 empty offset", {5'b0, prio_add_o}, 8'h06);

    // R11 specific variants
    wr(1'b0, 8'h62);
    chk("R11 specific clear", isr_clr_o, 8'h04);
    chk("R11 specific keeps offset", {5'b0, prio_add_o}, 8'h06);
    wr(1'b0, 8'hE1);
    chk("R11 specific rotate clear", isr_clr_o, 8'h02);
    chk("R11 specific rotate offset", {5'b0, prio_add_o}, 8'h02);
    wr(1'b0, 8'hC7);
    chk("R11 set prio wrap", {5'b0, prio_add_o}, 8'h00);
    wr(1'b0, 8'hC1);
    wr(1'b0, 8'h40);
    chk("R11 code 2 no strobe", isr_clr_o, 8'h00);
    chk("R11 code 2 offset", {5'b0, prio_add_o}, 8'h02);

    // R2 clears offset and read select
    wr(1'b0, 8'h0B);
    wr(1'b0, 8'h80);
    wr(1'b0, 8'h10);
    chk("R2 offset cleared", {5'b0, prio_add_o}, 8'h00);
    chk("R2 rotate cleared", {7'b0, rot_aeoi_o}, 8'h00);
    rd(1'b0, 8'h5A, "R2 read select back to irr");

    repeat (2) @(negedge clk_i);
    finish_run();
  end
endmodule